// File: doc/BRIEF.md
# Programmable legacy I/O chip-select decoder

This block watches I/O cycles on a simple host bus and turns them into active-low chip selects for legacy peripherals. The bus is an address, a read strobe and a write strobe. The peripherals are two disk channels, a keyboard controller, port 92, a parallel port and a configuration RAM. The block also drives the address-latch, read and write strobes of a real-time clock. Any access it claims also asserts one shared output enable for the transceiver of an 8-bit peripheral bus.

Two 8-bit configuration registers decide which peripheral groups are decoded. The host reads and writes them through a small configuration port, and reset loads defaults into both. The decode outputs are combinational from the address, the strobes and the registered enables. A write to a register therefore changes the decoding from the next clock.

Top module: `lio_csdec`

## Requirements
- R1: After reset, offset 4Eh reads 13h (the first register) and offset 4Fh reads CFh (the second register). Any other offset reads 00h.
- R2: A configuration write at 4Eh or 4Fh is visible on `cfg_rdata` from the next clock, and all 8 bits read back as written. A write to any other offset changes neither register.
- R3: When bit 4 of the first register is 1, an access to 1F0h–1F7h or 3F6h drives `cs_n[0]` low, and an access to 170h–177h or 376h drives `cs_n[1]` low. Each of these also drives `xcvr_oe_n` low. When the bit is 0, these addresses produce neither output.
- R4: An access to 3F7h or 377h always drives `xcvr_oe_n` low, whatever the enable bits hold, and drives no chip select.
- R5: When bit 1 of the first register is 1, an access to 60h or 64h drives `cs_n[2]` and `xcvr_oe_n` low. When the bit is 0, these addresses produce neither output. Accesses to 62h and 66h are never decoded.
- R6: When bit 0 of the first register is 1, an access in 70h–77h drives `xcvr_oe_n` low. Within that range:
  - a write to an even address drives `rtc_ale_n` low;
  - a read of an odd address drives `rtc_rd_n` low;
  - a write to an odd address drives `rtc_wr_n` low.
  When the bit is 0, none of these four outputs responds.
- R7: When bit 7 of the second register is 1, a read or write in 0800h–08FFh drives `cs_n[5]` and `xcvr_oe_n` low, together with `cram_rd_n` (read) or `cram_wr_n` (write). A write to 0C00h drives only `cs_n[5]` and `xcvr_oe_n`. A read of 0C00h is not decoded. When the bit is 0, none of this happens.
- R8: When bit 6 of the second register is 1, an access to 92h drives `cs_n[3]` and `xcvr_oe_n` low. When the bit is 0, the access is not decoded.
- R9: Bits 5:4 of the second register pick the parallel port decoded on `cs_n[4]` (with `xcvr_oe_n`):
  - 00 selects 3BCh–3BFh;
  - 01 selects 378h–37Fh;
  - 10 selects 278h–27Fh;
  - 11 decodes no parallel port.
- R10: With neither strobe asserted, every output is high. At most one bit of `cs_n` is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| cs_n | output | 6 | Chip selects, active low: 0 disk primary, 1 disk secondary, 2 keyboard, 3 port 92, 4 parallel port, 5 configuration RAM |
| rtc_ale_n | output | 1 | Clock address-latch strobe, active low |
| rtc_rd_n | output | 1 | Clock read strobe, active low |
| rtc_wr_n | output | 1 | Clock write strobe, active low |
| cram_rd_n | output | 1 | Configuration RAM read strobe, active low |
| cram_wr_n | output | 1 | Configuration RAM write strobe, active low |
| xcvr_oe_n | output | 1 | Peripheral bus transceiver enable, active low |

## Verification
The hardest situations to reach are those where a disabled group meets an address that stays decoded. Examples are 3F7h or 377h with the disk enable cleared, a write to 0C00h with the configuration RAM window open but no RAM strobe, and each parallel-port selection against the two ranges it must not claim. Uniform random addresses almost never land on these points. The stimulus therefore draws most addresses from a list of boundary and neighbour addresses, and draws the rest from the RAM window and the full space. Random register writes are interleaved so that every enable combination meets every listed address. Directed sequences then force each enable bit off and on around the exceptional addresses.

// File: rtl/lio_pkg.sv
package lio_pkg;

  localparam int NCS = 6;
  localparam int CS_IDE_P = 0;
  localparam int CS_IDE_S = 1;
  localparam int CS_KBC   = 2;
  localparam int CS_P92   = 3;
  localparam int CS_LPT   = 4;
  localparam int CS_CRAM  = 5;

  localparam int NWIN      = 15;
  localparam int W_IDE_P0  = 0;
  localparam int W_IDE_P1  = 1;
  localparam int W_IDE_S0  = 2;
  localparam int W_IDE_S1  = 3;
  localparam int W_AUX_P   = 4;
  localparam int W_AUX_S   = 5;
  localparam int W_KBC0    = 6;
  localparam int W_KBC1    = 7;
  localparam int W_RTC     = 8;
  localparam int W_P92     = 9;
  localparam int W_LPT_A   = 10;
  localparam int W_LPT_B   = 11;
  localparam int W_LPT_C   = 12;
  localparam int W_CRAM    = 13;
  localparam int W_CRAM_X  = 14;

  typedef enum logic [1:0] {
    LPT_SEL_A   = 2'b00,
    LPT_SEL_B   = 2'b01,
    LPT_SEL_C   = 2'b10,
    LPT_SEL_OFF = 2'b11
  } lpt_sel_e;

  function automatic int win_base(int idx);
    case (idx)
      W_IDE_P0: return 'h1F0;
      W_IDE_P1: return 'h3F6;
      W_IDE_S0: return 'h170;
      W_IDE_S1: return 'h376;
      W_AUX_P:  return 'h3F7;
      W_AUX_S:  return 'h377;
      W_KBC0:   return 'h060;
      W_KBC1:   return 'h064;
      W_RTC:    return 'h070;
      W_P92:    return 'h092;
      W_LPT_A:  return 'h3BC;
      W_LPT_B:  return 'h378;
      W_LPT_C:  return 'h278;
      W_CRAM:   return 'h800;
      default:  return 'hC00;
    endcase
  endfunction

  function automatic int win_size(int idx);
    case (idx)
      W_IDE_P0, W_IDE_S0, W_RTC, W_LPT_B, W_LPT_C: return 8;
      W_LPT_A: return 4;
      W_CRAM:  return 256;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/lio_cfg_regs.sv
module lio_cfg_regs #(
  parameter int          DW    = 8,
  parameter logic [7:0]  OFS_A = 8'h4E,
  parameter logic [7:0]  OFS_B = 8'h4F,
  parameter logic [DW-1:0] RST_A = 8'h13,
  parameter logic [DW-1:0] RST_B = 8'hCF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          en_ide,
  output logic          en_kbc,
  output logic          en_rtc,
  output logic          en_cram,
  output logic          en_p92,
  output logic [1:0]    lpt_sel
);

  logic [DW-1:0] reg_a;
  logic [DW-1:0] reg_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= RST_A;
      reg_b <= RST_B;
    end else if (cfg_we) begin
      if (cfg_addr == OFS_A) reg_a <= cfg_wdata;
      if (cfg_addr == OFS_B) reg_b <= cfg_wdata;
    end
  end

  always_comb begin
    if (cfg_addr == OFS_A)      cfg_rdata = reg_a;
    else if (cfg_addr == OFS_B) cfg_rdata = reg_b;
    else                        cfg_rdata = '0;
  end

  assign en_rtc  = reg_a[0];
  assign en_kbc  = reg_a[1];
  assign en_ide  = reg_a[4];
  assign lpt_sel = reg_b[5:4];
  assign en_p92  = reg_b[6];
  assign en_cram = reg_b[7];

  // R1: reset loads the defaults
  a_r1_reset_defaults: assert property (@(posedge clk)
    rst |=> (reg_a == RST_A && reg_b == RST_B));

  // R2: a write lands on the next clock
  a_r2_write_b: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == OFS_B) |=> (reg_b == $past(cfg_wdata)));

  // R2: other offsets leave both registers alone
  a_r2_other_ofs: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr != OFS_A && cfg_addr != OFS_B) |=> ($stable(reg_a) && $stable(reg_b)));

endmodule

// File: rtl/lio_win_match.sv
module lio_win_match #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int SIZE   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SIZE);

  logic [ADDR_W:0] ext;
  assign ext = {1'b0, addr};
  assign hit = (ext >= LO) && (ext < HI);

endmodule

// File: rtl/lio_addr_decode.sv
module lio_addr_decode
  import lio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NWIN-1:0]   hits
);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    lio_win_match #(
      .ADDR_W (ADDR_W),
      .BASE   (win_base(i)),
      .SIZE   (win_size(i))
    ) i_match (
      .addr (addr),
      .hit  (hits[i])
    );
  end

endmodule

// File: rtl/lio_cs_encode.sv
module lio_cs_encode
  import lio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NWIN-1:0] hits,
  input  logic            addr_lsb,
  input  logic            io_rd,
  input  logic            io_wr,
  input  logic            en_ide,
  input  logic            en_kbc,
  input  logic            en_rtc,
  input  logic            en_cram,
  input  logic            en_p92,
  input  logic [1:0]      lpt_sel,
  output logic [NCS-1:0]  cs_n,
  output logic            rtc_ale_n,
  output logic            rtc_rd_n,
  output logic            rtc_wr_n,
  output logic            cram_rd_n,
  output logic            cram_wr_n,
  output logic            xcvr_oe_n
);

  logic           acc;
  logic [NCS-1:0] cs_act;
  logic           lpt_hit;
  logic           rtc_act;
  logic           aux_act;

  assign acc = io_rd | io_wr;

  always_comb begin
    case (lpt_sel_e'(lpt_sel))
      LPT_SEL_A: lpt_hit = hits[W_LPT_A];
      LPT_SEL_B: lpt_hit = hits[W_LPT_B];
      LPT_SEL_C: lpt_hit = hits[W_LPT_C];
      default:   lpt_hit = 1'b0;
    endcase
  end

  always_comb begin
    cs_act           = '0;
    cs_act[CS_IDE_P] = acc & en_ide & (hits[W_IDE_P0] | hits[W_IDE_P1]);
    cs_act[CS_IDE_S] = acc & en_ide & (hits[W_IDE_S0] | hits[W_IDE_S1]);
    cs_act[CS_KBC]   = acc & en_kbc & (hits[W_KBC0] | hits[W_KBC1]);
    cs_act[CS_P92]   = acc & en_p92 & hits[W_P92];
    cs_act[CS_LPT]   = acc & lpt_hit;
    cs_act[CS_CRAM]  = en_cram & ((acc & hits[W_CRAM]) | (io_wr & hits[W_CRAM_X]));
  end

  assign rtc_act = acc & en_rtc & hits[W_RTC];
  assign aux_act = acc & (hits[W_AUX_P] | hits[W_AUX_S]);

  assign cs_n      = ~cs_act;
  assign rtc_ale_n = ~(rtc_act & io_wr & ~addr_lsb);
  assign rtc_rd_n  = ~(rtc_act & io_rd & addr_lsb);
  assign rtc_wr_n  = ~(rtc_act & io_wr & addr_lsb);
  assign cram_rd_n = ~(en_cram & io_rd & hits[W_CRAM]);
  assign cram_wr_n = ~(en_cram & io_wr & hits[W_CRAM]);
  assign xcvr_oe_n = ~((|cs_act) | rtc_act | aux_act);

  // R10: never two chip selects at once
  a_r10_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R10: no strobe, nothing driven
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(io_rd || io_wr) |-> (&cs_n && rtc_ale_n && rtc_rd_n && rtc_wr_n &&
                           cram_rd_n && cram_wr_n && xcvr_oe_n));

  // R4: auxiliary disk ports always open the transceiver
  a_r4_aux_xcvr: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && (hits[W_AUX_P] || hits[W_AUX_S])) |-> (!xcvr_oe_n && &cs_n));

  // R6: clock strobes silent when disabled
  a_r6_rtc_off: assert property (@(posedge clk) disable iff (rst)
    !en_rtc |-> (rtc_ale_n && rtc_rd_n && rtc_wr_n));

  // R7: RAM strobes only inside the window
  a_r7_cram_window: assert property (@(posedge clk) disable iff (rst)
    (!cram_rd_n || !cram_wr_n) |-> (hits[W_CRAM] && !cs_n[CS_CRAM] && !xcvr_oe_n));

endmodule

// File: rtl/lio_csdec.sv
module lio_csdec
  import lio_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] OFS_A  = 8'h4E,
  parameter logic [7:0] OFS_B  = 8'h4F,
  parameter logic [7:0] RST_A  = 8'h13,
  parameter logic [7:0] RST_B  = 8'hCF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [NCS-1:0]    cs_n,
  output logic              rtc_ale_n,
  output logic              rtc_rd_n,
  output logic              rtc_wr_n,
  output logic              cram_rd_n,
  output logic              cram_wr_n,
  output logic              xcvr_oe_n
);

  logic            en_ide, en_kbc, en_rtc, en_cram, en_p92;
  logic [1:0]      lpt_sel;
  logic [NWIN-1:0] hits;

  lio_cfg_regs #(
    .DW    (8),
    .OFS_A (OFS_A),
    .OFS_B (OFS_B),
    .RST_A (RST_A),
    .RST_B (RST_B)
  ) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .en_ide    (en_ide),
    .en_kbc    (en_kbc),
    .en_rtc    (en_rtc),
    .en_cram   (en_cram),
    .en_p92    (en_p92),
    .lpt_sel   (lpt_sel)
  );

  lio_addr_decode #(
    .ADDR_W (ADDR_W)
  ) i_dec (
    .addr (io_addr),
    .hits (hits)
  );

  lio_cs_encode i_enc (
    .clk       (clk),
    .rst       (rst),
    .hits      (hits),
    .addr_lsb  (io_addr[0]),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .en_ide    (en_ide),
    .en_kbc    (en_kbc),
    .en_rtc    (en_rtc),
    .en_cram   (en_cram),
    .en_p92    (en_p92),
    .lpt_sel   (lpt_sel),
    .cs_n      (cs_n),
    .rtc_ale_n (rtc_ale_n),
    .rtc_rd_n  (rtc_rd_n),
    .rtc_wr_n  (rtc_wr_n),
    .cram_rd_n (cram_rd_n),
    .cram_wr_n (cram_wr_n),
    .xcvr_oe_n (xcvr_oe_n)
  );

  // R7: a read at the extra RAM port is never claimed
  a_r7_cramx_read: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && io_addr == ADDR_W'('hC00)) |-> (&cs_n && xcvr_oe_n));

endmodule

// File: tb/test_lio_csdec.sv
`timescale 1ns/1ps
module test_lio_csdec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [5:0]  cs_n;
  logic        rtc_ale_n, rtc_rd_n, rtc_wr_n, cram_rd_n, cram_wr_n, xcvr_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] sa, sb;

  always #10 clk = ~clk;

  lio_csdec i_lio_csdec (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .io_rd(io_rd), .io_wr(io_wr), .cs_n(cs_n), .rtc_ale_n(rtc_ale_n),
    .rtc_rd_n(rtc_rd_n), .rtc_wr_n(rtc_wr_n), .cram_rd_n(cram_rd_n),
    .cram_wr_n(cram_wr_n), .xcvr_oe_n(xcvr_oe_n)
  );

  function automatic logic [11:0] exp_out(logic [15:0] a, logic rd, logic wr,
                                          logic [7:0] ra, logic [7:0] rb);
    logic [5:0] cs;
    logic ale, rrd, rwr, crd, cwr, x, acc, rtc;
    cs = '0; ale = 0; rrd = 0; rwr = 0; crd = 0; cwr = 0; x = 0;
    acc = rd | wr;
    rtc = acc && ra[0] && a >= 16'h70 && a <= 16'h77;
    if (acc) begin
      if (ra[4] && ((a >= 16'h1F0 && a <= 16'h1F7) || a == 16'h3F6)) cs[0] = 1;
      if (ra[4] && ((a >= 16'h170 && a <= 16'h177) || a == 16'h376)) cs[1] = 1;
      if (ra[1] && (a == 16'h60 || a == 16'h64)) cs[2] = 1;
      if (rb[6] && a == 16'h92) cs[3] = 1;
      case (rb[5:4])
        2'b00: if (a >= 16'h3BC && a <= 16'h3BF) cs[4] = 1;
        2'b01: if (a >= 16'h378 && a <= 16'h37F) cs[4] = 1;
        2'b10: if (a >= 16'h278 && a <= 16'h27F) cs[4] = 1;
        default: ;
      endcase
      if (rb[7] && a >= 16'h800 && a <= 16'h8FF) begin
        cs[5] = 1; crd = rd; cwr = wr;
      end
      if (rb[7] && wr && a == 16'hC00) cs[5] = 1;
      if (a == 16'h3F7 || a == 16'h377) x = 1;
      ale = rtc && wr && !a[0];
      rrd = rtc && rd && a[0];
      rwr = rtc && wr && a[0];
    end
    x = x | (|cs) | rtc;
    return {~x, ~cwr, ~crd, ~rwr, ~rrd, ~ale, ~cs};
  endfunction

  function automatic string tag_for(logic [15:0] a, logic rd, logic wr);
    if (!(rd | wr)) return "R10";
    if (a == 16'h3F7 || a == 16'h377) return "R4";
    if ((a >= 16'h1F0 && a <= 16'h1F7) || a == 16'h3F6 ||
        (a >= 16'h170 && a <= 16'h177) || a == 16'h376) return "R3";
    if (a >= 16'h60 && a <= 16'h66) return "R5";
    if (a >= 16'h70 && a <= 16'h77) return "R6";
    if ((a >= 16'h800 && a <= 16'h8FF) || a == 16'hC00) return "R7";
    if (a == 16'h92) return "R8";
    if (a >= 16'h278 && a <= 16'h3BF) return "R9";
    return "R10";
  endfunction

  task automatic check_val(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [15:0] a, logic rd, logic wr, string req);
    logic [11:0] got;
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr;
    #1;
    got = {xcvr_oe_n, cram_wr_n, cram_rd_n, rtc_wr_n, rtc_rd_n, rtc_ale_n, cs_n};
    check_val(req, {4'h0, got}, {4'h0, exp_out(a, rd, wr, sa, sb)});
    if ($countones(~cs_n) > 1) check_val("R10", 16'(~cs_n), 16'h0);
  endtask

  task automatic cfg_write(logic [7:0] ofs, logic [7:0] d);
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    cfg_addr = ofs; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    if (ofs == 8'h4E) sa = d;
    if (ofs == 8'h4F) sb = d;
  endtask

  task automatic cfg_check(logic [7:0] ofs, string req);
    @(negedge clk);
    cfg_addr = ofs;
    #1;
    check_val(req, {8'h0, cfg_rdata},
              {8'h0, (ofs == 8'h4E) ? sa : (ofs == 8'h4F) ? sb : 8'h00});
  endtask

  function automatic logic [15:0] pick_addr(int unsigned r);
    case (r % 30)
      0: return 16'h1F0;  1: return 16'h1F7;  2: return 16'h1F8;
      3: return 16'h3F6;  4: return 16'h3F7;  5: return 16'h170;
      6: return 16'h177;  7: return 16'h376;  8: return 16'h377;
      9: return 16'h060;  10: return 16'h062; 11: return 16'h064;
      12: return 16'h066; 13: return 16'h070; 14: return 16'h071;
      15: return 16'h077; 16: return 16'h078; 17: return 16'h092;
      18: return 16'h3BC; 19: return 16'h3BF; 20: return 16'h378;
      21: return 16'h37F; 22: return 16'h278; 23: return 16'h27F;
      24: return 16'hC00; 25: return 16'h800; 26: return 16'h8FF;
      27: return 16'h900;
      28: return 16'h0800 | 16'(r[15:8]);
      default: return 16'(r >> 8);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    sa = 8'h13; sb = 8'hCF;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: defaults after reset
    cfg_check(8'h4E, "R1");
    cfg_check(8'h4F, "R1");
    cfg_check(8'h10, "R1");
    // R10: idle bus
    access(16'h1F0, 0, 0, "R10");
    access(16'h070, 0, 0, "R10");

    // default decode
    access(16'h1F3, 1, 0, "R3");
    access(16'h3F6, 0, 1, "R3");
    access(16'h174, 1, 0, "R3");
    access(16'h060, 1, 0, "R5");
    access(16'h062, 1, 0, "R5");
    access(16'h066, 0, 1, "R5");
    access(16'h070, 0, 1, "R6");
    access(16'h071, 1, 0, "R6");
    access(16'h071, 0, 1, "R6");
    access(16'h070, 1, 0, "R6");
    access(16'h092, 1, 0, "R8");
    access(16'h3BD, 1, 0, "R9");
    access(16'h378, 1, 0, "R9");
    access(16'h8A5, 1, 0, "R7");
    access(16'h8A5, 0, 1, "R7");
    access(16'hC00, 0, 1, "R7");
    access(16'hC00, 1, 0, "R7");
    access(16'h3F7, 1, 0, "R4");

    // R2: writes land next clock, other offsets ignored
    cfg_write(8'h4E, 8'hA5);
    cfg_check(8'h4E, "R2");
    cfg_write(8'h4D, 8'hFF);
    cfg_check(8'h4E, "R2");
    cfg_check(8'h4F, "R2");
    cfg_write(8'h4F, 8'h3A);
    cfg_check(8'h4F, "R2");

    // all groups disabled: exceptional addresses
    cfg_write(8'h4E, 8'h00);
    cfg_write(8'h4F, 8'h30);
    access(16'h3F7, 0, 1, "R4");
    access(16'h377, 1, 0, "R4");
    access(16'h3F6, 1, 0, "R3");
    access(16'h1F0, 0, 1, "R3");
    access(16'h064, 1, 0, "R5");
    access(16'h073, 0, 1, "R6");
    access(16'h092, 0, 1, "R8");
    access(16'h800, 0, 1, "R7");
    access(16'hC00, 0, 1, "R7");
    access(16'h3BC, 1, 0, "R9");

    // R9: each selection against all three ranges
    for (int s = 0; s < 4; s++) begin
      cfg_write(8'h4F, {2'b00, 2'(s), 4'h0});
      access(16'h3BE, 1, 0, "R9");
      access(16'h37B, 0, 1, "R9");
      access(16'h27F, 1, 0, "R9");
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if (r % 8 == 0) begin
        logic [7:0] ofs;
        ofs = (r[4]) ? 8'h4E : (r[5] ? 8'h4F : 8'(r >> 24));
        cfg_write(ofs, 8'($urandom));
        cfg_check(ofs, "R2");
      end else begin
        logic [15:0] a;
        logic rd, wr;
        a = pick_addr($urandom);
        case ((r >> 4) % 3)
          0: begin rd = 0; wr = 0; end
          1: begin rd = 1; wr = 0; end
          default: begin rd = 0; wr = 1; end
        endcase
        access(a, rd, wr, tag_for(a, rd, wr));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule